// File: doc/BRIEF.md
# CAN Bit Timing and Bus Sampler

This block turns a fast system clock into CAN bit timing and decides the value of each bit seen on the receive line. A programmable prescaler divides the clock into time quanta. Every bit period is split into a one-quantum sync segment, a first phase segment and a second phase segment. The sample point sits at the end of the first phase segment. There, the block produces a one-clock strobe together with the decided bit value. That value is either a single sample or a two-out-of-three vote over the last three quanta.

The receive line passes through a two-flop synchronizer. A recessive-to-dominant transition then realigns the bit timing. An edge in the first phase segment stretches that segment, and an edge in the second phase segment trims it. The correction is capped by a programmable jump width, and at most one correction is made per bit. Software sees two registers: the timing word and an error warning limit. Both are writable only while the controller is held in configuration mode. The limit is compared against externally supplied transmit and receive error counts to raise a warning output.

Top module: `cbt_bit_timing`

## Requirements
- R1: With no falling edge on the line, a quantum is (psc+1) clocks and a bit period is (psc+1)*(3+seg1+seg2) clocks. The sync segment lasts one quantum.
- R2: Timing word layout: psc in bits 9:0, jump in bits 11:10, seg1 in bits 15:12, seg2 in bits 18:16, triple-sample enable in bit 23. All other bits, including 31:24, read as zero. Register select 0 addresses the timing word and select 1 the 8-bit warning limit, which sits in bits 7:0.
- R3: A write with wr_en=1 takes effect only while cfg_mode=1. With cfg_mode=0 the write is ignored. Reads through rd_sel/rd_data work in either mode.
- R4: At the end of seg1, bit_stb pulses for exactly one clock. In single mode, bit_val is the synchronized line level at that quantum. Rising edges never change the timing.
- R5: With triple sampling on, bit_val is the majority of the synchronized line over the last three quanta ending at the sample point, so a one-quantum spike is rejected.
- R6: A falling edge during seg1 lengthens seg1 by min(quanta elapsed in seg1 including the current one, jump+1).
- R7: A falling edge during seg2 shortens seg2 by min(quanta left in seg2 including the current one, jump+1).
- R8: A falling edge during the sync segment causes no correction. Only the first falling edge in a bit period is acted upon.
- R9: One clock after its inputs change, warn is 1 when the transmit or the receive error count is greater than or equal to the limit. Otherwise warn is 0.
- R10: After reset, the timing word reads 0, the limit reads 96, and bit_stb and warn are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_raw | input | 1 | Asynchronous receive line, 1 = recessive |
| cfg_mode | input | 1 | Configuration mode; register writes allowed when 1 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 timing word, 1 warning limit |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 timing word, 1 warning limit |
| rd_data | output | 32 | Read data for the selected register |
| tx_errs | input | 8 | Transmit error count |
| rx_errs | input | 8 | Receive error count |
| bit_val | output | 1 | Decided bit value, valid with bit_stb |
| bit_stb | output | 1 | One-clock strobe at the sample point |
| warn | output | 1 | Error warning flag |

## Verification
The assertions assume that the timing word changes only through writes made in configuration mode. They also assume that the correction registers never exceed the largest encodable jump. Their tick-spacing check only applies when no write could have landed in the preceding two clocks. The stimulus keeps within these assumptions: every configuration change is followed by three full bit periods with a steady line before any measurement. Falling and rising edges are then placed at a chosen clock offset from an observed strobe, so each edge lands in a known segment and quantum.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int WORD_W  = 32;
    localparam int PSC_W   = 10;
    localparam int JMP_W   = 2;
    localparam int S1_W    = 4;
    localparam int S2_W    = 3;
    localparam int LIM_W   = 8;
    localparam int ERR_W   = 8;

    localparam int POS_PSC = 0;
    localparam int POS_JMP = 10;
    localparam int POS_S1  = 12;
    localparam int POS_S2  = 16;
    localparam int POS_TRI = 23;

    localparam logic [LIM_W-1:0] LIM_RST = LIM_W'(96);

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_SEG1 = 2'd1,
        PH_SEG2 = 2'd2
    } phase_e;

    typedef struct packed {
        logic              triple;
        logic [S2_W-1:0]   seg2;
        logic [S1_W-1:0]   seg1;
        logic [JMP_W-1:0]  jump;
        logic [PSC_W-1:0]  psc;
    } timing_t;

    function automatic timing_t word_to_timing(input logic [WORD_W-1:0] w);
        timing_t t;
        t.psc    = w[POS_PSC +: PSC_W];
        t.jump   = w[POS_JMP +: JMP_W];
        t.seg1   = w[POS_S1  +: S1_W];
        t.seg2   = w[POS_S2  +: S2_W];
        t.triple = w[POS_TRI];
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] timing_to_word(input timing_t t);
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_PSC +: PSC_W] = t.psc;
        w[POS_JMP +: JMP_W] = t.jump;
        w[POS_S1  +: S1_W]  = t.seg1;
        w[POS_S2  +: S2_W]  = t.seg2;
        w[POS_TRI]          = t.triple;
        return w;
    endfunction

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/cbt_rx_sync.sv
module cbt_rx_sync #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_raw,
    output logic rx_sync,
    output logic fall
);
    logic [1:0] stage_q;
    logic       prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= {2{IDLE_LVL}};
            prev_q  <= IDLE_LVL;
        end else begin
            stage_q <= {stage_q[0], rx_raw};
            prev_q  <= stage_q[1];
        end
    end

    assign rx_sync = stage_q[1];
    assign fall    = prev_q & ~stage_q[1];

    // a detected falling edge traces back to a low line two clocks earlier
    p_fall_src_r8: assert property (@(posedge clk) disable iff (rst)
        fall |-> ($past(rx_raw, 2) == 1'b0));

endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (rst || tick) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/cbt_bitseq.sv
module cbt_bitseq
    import cbt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    rx,
    input  logic    fall,
    input  timing_t cfg,
    output logic    bit_val,
    output logic    bit_stb
);
    localparam int QW = S1_W + 2;
    localparam logic [QW-1:0] JMAX = QW'(1 << JMP_W);

    phase_e          phase_q;
    logic [QW-1:0]   qcnt_q, ext_q, shr_q;
    logic            used_q;
    logic [1:0]      hist_q;

    logic [QW-1:0]   jlen, s1_end, s2_len, err1, err2;
    logic            sample_v, s1_done, s2_done;

    function automatic logic [QW-1:0] lesser(input logic [QW-1:0] a, input logic [QW-1:0] b);
        return (a < b) ? a : b;
    endfunction

    always_comb begin
        jlen     = QW'(cfg.jump) + 1'b1;
        s1_end   = QW'(cfg.seg1) + ext_q;
        s2_len   = QW'(cfg.seg2) + 1'b1;
        err1     = qcnt_q + 1'b1;
        err2     = (qcnt_q < s2_len) ? (s2_len - qcnt_q) : '0;
        s1_done  = (qcnt_q >= s1_end);
        s2_done  = ((qcnt_q + shr_q) >= QW'(cfg.seg2));
        sample_v = cfg.triple ? vote3(hist_q[1], hist_q[0], rx) : rx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_SYNC;
            qcnt_q  <= '0;
            ext_q   <= '0;
            shr_q   <= '0;
            used_q  <= 1'b0;
            hist_q  <= 2'b11;
            bit_val <= 1'b1;
            bit_stb <= 1'b0;
        end else begin
            bit_stb <= 1'b0;
            if (fall && !used_q) begin
                used_q <= 1'b1;
                case (phase_q)
                    PH_SEG1: ext_q <= lesser(err1, jlen);
                    PH_SEG2: shr_q <= lesser(err2, jlen);
                    default: ;
                endcase
            end
            if (tick) begin
                hist_q <= {hist_q[0], rx};
                case (phase_q)
                    PH_SYNC: begin
                        phase_q <= PH_SEG1;
                        qcnt_q  <= '0;
                    end
                    PH_SEG1: begin
                        if (s1_done) begin
                            bit_stb <= 1'b1;
                            bit_val <= sample_v;
                            phase_q <= PH_SEG2;
                            qcnt_q  <= '0;
                        end else begin
                            qcnt_q  <= qcnt_q + 1'b1;
                        end
                    end
                    PH_SEG2: begin
                        if (s2_done) begin
                            phase_q <= PH_SYNC;
                            qcnt_q  <= '0;
                            ext_q   <= '0;
                            shr_q   <= '0;
                            used_q  <= 1'b0;
                        end else begin
                            qcnt_q  <= qcnt_q + 1'b1;
                        end
                    end
                    default: begin
                        phase_q <= PH_SYNC;
                        qcnt_q  <= '0;
                    end
                endcase
            end
        end
    end

    p_stb_single_r4: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    p_sync_one_tq_r1: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SYNC && tick) |=> (phase_q == PH_SEG1));

    p_ext_bound_r6: assert property (@(posedge clk) disable iff (rst)
        ext_q <= JMAX);

    p_shr_bound_r7: assert property (@(posedge clk) disable iff (rst)
        shr_q <= JMAX);

    p_one_resync_r8: assert property (@(posedge clk) disable iff (rst)
        (used_q && phase_q != PH_SEG2) |=> used_q);

endmodule

// File: rtl/cbt_regs.sv
module cbt_regs
    import cbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_mode,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic [ERR_W-1:0]  tx_errs,
    input  logic [ERR_W-1:0]  rx_errs,
    output timing_t           tim,
    output logic              warn
);
    timing_t          tim_q;
    logic [LIM_W-1:0] lim_q;
    logic             warn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tim_q  <= '0;
            lim_q  <= LIM_RST;
            warn_q <= 1'b0;
        end else begin
            if (cfg_mode && wr_en) begin
                if (wr_sel) lim_q <= wr_data[LIM_W-1:0];
                else        tim_q <= word_to_timing(wr_data);
            end
            warn_q <= (ERR_W'(lim_q) <= tx_errs) || (ERR_W'(lim_q) <= rx_errs);
        end
    end

    assign rd_data = rd_sel ? WORD_W'(lim_q) : timing_to_word(tim_q);
    assign tim     = tim_q;
    assign warn    = warn_q;

    p_locked_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> ($stable(tim_q) && $stable(lim_q)));

endmodule

// File: rtl/cbt_bit_timing.sv
module cbt_bit_timing
    import cbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_raw,
    input  logic              cfg_mode,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic [ERR_W-1:0]  tx_errs,
    input  logic [ERR_W-1:0]  rx_errs,
    output logic              bit_val,
    output logic              bit_stb,
    output logic              warn
);
    timing_t tim;
    logic    tick, rx_s, rx_fall;

    cbt_regs u_regs (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .tx_errs(tx_errs), .rx_errs(rx_errs), .tim(tim), .warn(warn)
    );

    cbt_prescaler #(.DIV_W(PSC_W)) u_psc (
        .clk(clk), .rst(rst), .div(tim.psc), .tick(tick)
    );

    cbt_rx_sync #(.IDLE_LVL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .rx_raw(rx_raw), .rx_sync(rx_s), .fall(rx_fall)
    );

    cbt_bitseq u_seq (
        .clk(clk), .rst(rst), .tick(tick), .rx(rx_s), .fall(rx_fall),
        .cfg(tim), .bit_val(bit_val), .bit_stb(bit_stb)
    );

    // back-to-back quantum ticks only with a divide-by-one prescaler
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && $past(tick) && !$past(cfg_mode) && !$past(cfg_mode, 2))
            |-> (tim.psc == '0));

endmodule

// File: tb/sim_cbt_bit_timing.sv
module sim_cbt_bit_timing;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_raw = 1'b1;
    logic        cfg_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [7:0]  tx_errs = '0;
    logic [7:0]  rx_errs = '0;
    logic        bit_val, bit_stb, warn;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cbt_bit_timing u0 (
        .clk(clk), .rst(rst), .rx_raw(rx_raw), .cfg_mode(cfg_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .tx_errs(tx_errs), .rx_errs(rx_errs),
        .bit_val(bit_val), .bit_stb(bit_stb), .warn(warn)
    );

    // timing word vectors and expected bit periods in clocks
    localparam int NV = 5;
    localparam logic [31:0] VEC_CFG [NV] = '{32'h0000_0000, 32'h0001_2001,
                                             32'h0002_4003, 32'h0007_F000,
                                             32'h0003_5002};
    localparam int          VEC_PER [NV] = '{3, 12, 36, 25, 33};

    localparam logic [31:0] CFG_J1  = 32'h0003_5400; // psc0 seg1=5 seg2=3 jump=1
    localparam logic [31:0] CFG_J3  = 32'h0003_5C00; // same, jump=3
    localparam logic [31:0] CFG_TRI = 32'h0083_5400; // jump=1, triple

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d, input logic mode);
        @(negedge clk);
        cfg_mode = mode; wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; cfg_mode = 1'b0;
    endtask

    task automatic wait_stb();
        int n = 0;
        do begin @(negedge clk); n++; end while (!bit_stb && n < 2000);
    endtask

    task automatic settle(input logic lvl);
        rx_raw = lvl;
        repeat (3) wait_stb();
    endtask

    // from an observed strobe, drive up to three line changes at negedge offsets
    task automatic probe(input int ka, input logic va, input int kb, input logic vb,
                         input int kc, input logic vc,
                         output int i1, output int i2, output logic b1);
        int seen = 0;
        int k = 0;
        i1 = 0; i2 = 0; b1 = 1'b0;
        wait_stb();
        while (seen < 2 && k < 2000) begin
            @(negedge clk);
            k++;
            if (bit_stb) begin
                if (seen == 0) begin i1 = k; b1 = bit_val; end
                else i2 = k;
                seen++;
            end
            if (k == ka) rx_raw = va;
            if (k == kb) rx_raw = vb;
            if (k == kc) rx_raw = vc;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int i1, i2;
        logic b1;
        logic [31:0] keep;

        repeat (5) @(negedge clk);
        check("R10 stb in reset", {31'd0, bit_stb}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        rd_sel = 1'b0; #1;
        check("R10 timing reset", rd_data, 32'h0);
        rd_sel = 1'b1; #1;
        check("R10 limit reset", rd_data, 32'd96);
        check("R10 warn reset", {31'd0, warn}, 32'd0);
        check("R10 stb after reset", {31'd0, bit_stb}, 32'd0);
        rd_sel = 1'b0;

        // R1 / R2: period table
        for (int v = 0; v < NV; v++) begin
            reg_write(1'b0, VEC_CFG[v], 1'b1);
            #1;
            check("R2 readback", rd_data, VEC_CFG[v]);
            settle(1'b1);
            probe(-1, 1'b1, -1, 1'b1, -1, 1'b1, i1, i2, b1);
            check("R1 bit period", i1, VEC_PER[v]);
            check("R1 next period", i2 - i1, VEC_PER[v]);
        end

        // R2: reserved bits read zero
        reg_write(1'b0, 32'hFFFF_FFFF, 1'b1);
        #1;
        check("R2 reserved timing bits", rd_data, 32'h0087_FFFF);
        reg_write(1'b1, 32'hFFFF_FFFF, 1'b1);
        rd_sel = 1'b1; #1;
        check("R2 limit width", rd_data, 32'h0000_00FF);

        // R3: writes locked outside configuration mode
        reg_write(1'b1, 32'd100, 1'b1);
        reg_write(1'b0, CFG_J1, 1'b1);
        reg_write(1'b0, 32'h0001_1111, 1'b0);
        rd_sel = 1'b0; #1;
        check("R3 timing locked", rd_data, CFG_J1);
        reg_write(1'b1, 32'd5, 1'b0);
        rd_sel = 1'b1; #1;
        check("R3 limit locked", rd_data, 32'd100);
        rd_sel = 1'b0;

        // R9: warning compare with limit 100; also shows ignored limit write
        @(negedge clk); tx_errs = 8'd50; rx_errs = 8'd0;
        @(negedge clk);
        check("R3 warn uses kept limit", {31'd0, warn}, 32'd0);
        tx_errs = 8'd99;
        @(negedge clk);
        check("R9 below limit", {31'd0, warn}, 32'd0);
        tx_errs = 8'd100;
        @(negedge clk);
        check("R9 tx at limit", {31'd0, warn}, 32'd1);
        tx_errs = 8'd0; rx_errs = 8'd150;
        @(negedge clk);
        check("R9 rx above limit", {31'd0, warn}, 32'd1);
        rx_errs = 8'd99;
        @(negedge clk);
        check("R9 both below", {31'd0, warn}, 32'd0);

        // bit period 11 clocks with CFG_J1
        settle(1'b1);
        probe(6, 1'b0, -1, 1'b0, -1, 1'b0, i1, i2, b1);
        check("R6 lengthen capped", i1, 32'd13);
        check("R4 sampled dominant", {31'd0, b1}, 32'd0);

        settle(1'b1);
        probe(3, 1'b0, -1, 1'b0, -1, 1'b0, i1, i2, b1);
        check("R6 lengthen by phase error", i1, 32'd12);

        settle(1'b1);
        probe(9, 1'b0, -1, 1'b0, -1, 1'b0, i1, i2, b1);
        check("R7 first bit unchanged", i1, 32'd11);
        check("R7 shorten capped", i2 - i1, 32'd9);
        check("R4 sampled recessive", {31'd0, b1}, 32'd1);

        settle(1'b1);
        probe(2, 1'b0, -1, 1'b0, -1, 1'b0, i1, i2, b1);
        check("R8 sync edge no correction", i1, 32'd11);

        settle(1'b0);
        probe(6, 1'b1, -1, 1'b1, -1, 1'b1, i1, i2, b1);
        check("R4 rising edge ignored", i1, 32'd11);
        check("R4 sampled after rise", {31'd0, b1}, 32'd1);

        reg_write(1'b0, CFG_J3, 1'b1);
        settle(1'b1);
        probe(3, 1'b0, 4, 1'b1, 6, 1'b0, i1, i2, b1);
        check("R8 single resync per bit", i1, 32'd12);

        // R5: one-quantum spike at the sample point
        reg_write(1'b0, CFG_J1, 1'b1);
        settle(1'b0);
        probe(8, 1'b1, 9, 1'b0, -1, 1'b0, i1, i2, b1);
        check("R4 single sample takes spike", {31'd0, b1}, 32'd1);

        reg_write(1'b0, CFG_TRI, 1'b1);
        settle(1'b0);
        probe(8, 1'b1, 9, 1'b0, -1, 1'b0, i1, i2, b1);
        check("R5 triple rejects spike", {31'd0, b1}, 32'd0);
        check("R5 triple timing", i1, 32'd11);

        settle(1'b1);
        probe(-1, 1'b1, -1, 1'b1, -1, 1'b1, i1, i2, b1);
        check("R5 triple steady recessive", {31'd0, b1}, 32'd1);

        keep = CFG_TRI;
        #1;
        check("R2 triple bit readback", rd_data, keep);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule